// File: doc/BRIEF.md
# Programmable Interval Timer

A 16-bit down-counting interval timer behind a small synchronous halfword register port. Software programs a control word (run, reload policy, interrupt enable, overwrite policy and a 4-bit prescale exponent) and a modulus. While running, a prescaler divides the clock by two and then by a further power of two. Each prescaled tick decrements the counter. A tick that finds the counter at zero raises an expiry flag and reloads the counter. The interrupt line is a level. It is high whenever the expiry flag and the interrupt enable are both set.

Three halfword registers are visible: control/status at byte offset 0, modulus at offset 2 and the live count at offset 4, which is read-only. The counter runs either periodically from the modulus or freely from 0xFFFF. A modulus write with the overwrite bit set loads the counter at once. A control write that only touches the interrupt enable or only clears the flag leaves counting undisturbed.

The counter is sequenced by a two-state machine. ST_IDLE: counter and prescaler hold; transition START (a restarting control write with the run bit 1) loads the start value, clears the prescaler and enters ST_COUNT. ST_COUNT: ticks decrement or reload the counter; transition STOP (a restarting control write with the run bit 0) returns to ST_IDLE holding the count; transition RESTART (a restarting control write with the run bit still 1) reloads the count and clears the prescaler while staying in ST_COUNT.

Top module: `pit16`

## Requirements
- R1: After reset the control, modulus and count registers read 0, the timer is stopped and irq is 0.
- R2: Control bit layout: bit 0 run, bit 1 reload-from-modulus, bit 2 expiry flag, bit 3 interrupt enable, bit 4 overwrite, bits 5 and 6 plain storage, bits 11:8 prescale exponent P; all other bits read 0. Offset 0 reads control, 2 the modulus, 4 the live count, any other offset reads 0 (rdata is valid in the same cycle as rd).
- R3: While running, the counter changes once every 2·2^P clock cycles, decrementing by one when it is non-zero.
- R4: Writing 1 to control bit 2 clears the flag, writing 0 leaves it, software can never set it; an expiry in the same cycle as a clear leaves the flag set.
- R5: irq is 1 exactly while the flag and the interrupt enable are both 1, and follows every register write from the next cycle.
- R6: A tick with the count at 0 sets the flag and loads the modulus when bit 1 is 1, or 0xFFFF when bit 1 is 0.
- R7: A control write that changes any stored bit other than bits 2 and 3 restarts: with run 1 the counter loads the new limit (modulus if the new bit 1 is 1, else 0xFFFF) and the prescaler clears; a write changing only bits 2 or 3 leaves counter and prescaler undisturbed.
- R8: While run is 0 the counter and prescaler hold and no expiry occurs.
- R9: Every modulus write clears the flag (unless an expiry occurs in that cycle).
- R10: A modulus write with overwrite (bit 4) set loads the written value into the counter in the next cycle; without overwrite the counter is untouched and the new value is used only at the next reload.
- R11: Writes to offset 4 or to any undefined offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the halfword register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt request |

## Verification
The counting path is exercised with periodic reload at the smallest divide, with a larger prescale, in free-run after an overwrite load, and stopped; comparing the live count each time separates a wrong divide ratio from a wrong reload source. Control writes are issued both as enable-only or flag-only changes and as real configuration changes, which tells the undisturbed path from the restart path. A flag clear is placed exactly on an expiry cycle to expose the set-over-clear priority, and modulus writes with and without overwrite show whether the counter or only the next reload picks up the value.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Control word bit positions (software visible layout)
    localparam int B_RUN    = 0;
    localparam int B_RELOAD = 1;
    localparam int B_FLAG   = 2;
    localparam int B_IE     = 3;
    localparam int B_OVW    = 4;
    localparam int B_SPARE0 = 5;
    localparam int B_SPARE1 = 6;
    localparam int PRE_LSB  = 8;

    // Byte offsets of the halfword registers
    localparam int OFF_CTRL  = 0;
    localparam int OFF_MOD   = 2;
    localparam int OFF_COUNT = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << PRE_W) + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] top;

    always_comb begin
        top    = (DIV_W'(2) << pre_i) - DIV_W'(1);
        tick_o = run_i && (div_q == top);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear_i) begin
            div_q <= '0;
        end else if (run_i) begin
            div_q <= tick_o ? '0 : div_q + DIV_W'(1);
        end
    end

    // Divide ratio is at least two, so ticks are never adjacent
    assert_no_back_to_back_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_o) |=> !tick_o);

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] start_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o,
    output logic             running_o
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_COUNT;
            ST_COUNT: if (stop_i)  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output / datapath process
    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)     cnt_d = start_val_i;
                else if (load_i) cnt_d = load_val_i;
            end
            ST_COUNT: begin
                if (stop_i) begin
                    cnt_d = cnt_q;
                end else if (start_i) begin
                    cnt_d = start_val_i;
                end else begin
                    expire_o = tick_i && (cnt_q == '0);
                    if (load_i)        cnt_d = load_val_i;
                    else if (expire_o) cnt_d = reload_val_i;
                    else if (tick_i)   cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o   = cnt_q;
    assign running_o = (state_q == ST_COUNT);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i && !load_i) |=> $stable(cnt_q));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && tick_i && cnt_q != '0 && !start_i && !stop_i && !load_i)
        |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_reload_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !load_i) |=> (cnt_q == $past(reload_val_i)));

    assert_no_expiry_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !expire_o);

endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              expire_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [PRE_W-1:0]  pre_o,
    output logic              restart_o,
    output logic              start_o,
    output logic              stop_o,
    output logic [DATA_W-1:0] start_val_o,
    output logic [DATA_W-1:0] reload_val_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] PRE_FIELD =
        DATA_W'(((1 << PRE_W) - 1) << PRE_LSB);
    localparam logic [DATA_W-1:0] LOW_BITS =
        (DATA_W'(1) << B_RUN)  | (DATA_W'(1) << B_RELOAD) | (DATA_W'(1) << B_IE) |
        (DATA_W'(1) << B_OVW)  | (DATA_W'(1) << B_SPARE0) | (DATA_W'(1) << B_SPARE1);
    localparam logic [DATA_W-1:0] CFG_KEEP     = PRE_FIELD | LOW_BITS;
    localparam logic [DATA_W-1:0] RESTART_MASK = CFG_KEEP & ~(DATA_W'(1) << B_IE);
    localparam logic [DATA_W-1:0] ALL_ONES     = '1;

    logic [DATA_W-1:0] cfg_q, mod_q;
    logic              flag_q, flag_d;
    logic              wr_ctrl, wr_mod;

    always_comb begin
        wr_ctrl   = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
        wr_mod    = wr_i && (addr_i == ADDR_W'(OFF_MOD));
        restart_o = wr_ctrl && (((cfg_q ^ wdata_i) & RESTART_MASK) != '0);
        start_o   = restart_o && wdata_i[B_RUN];
        stop_o    = restart_o && !wdata_i[B_RUN];
        load_o    = wr_mod && cfg_q[B_OVW];
        load_val_o   = wdata_i;
        start_val_o  = wdata_i[B_RELOAD] ? mod_q : ALL_ONES;
        reload_val_o = cfg_q[B_RELOAD]   ? mod_q : ALL_ONES;
        pre_o        = cfg_q[PRE_LSB +: PRE_W];
    end

    // Expiry flag: hardware set beats software clear
    always_comb begin
        flag_d = flag_q;
        if (expire_i)
            flag_d = 1'b1;
        else if ((wr_ctrl && wdata_i[B_FLAG]) || wr_mod)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mod_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (wr_ctrl) cfg_q <= wdata_i & CFG_KEEP;
            if (wr_mod)  mod_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (addr_i)
                ADDR_W'(OFF_CTRL):  rdata_o = cfg_q | (DATA_W'(flag_q) << B_FLAG);
                ADDR_W'(OFF_MOD):   rdata_o = mod_q;
                ADDR_W'(OFF_COUNT): rdata_o = count_i;
                default:            rdata_o = '0;
            endcase
        end
    end

    assign irq_o = flag_q && cfg_q[B_IE];

    assert_flag_set_by_hw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(expire_i));

    assert_flag_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata_i[B_FLAG] && !expire_i) |=> !flag_q);

    assert_mod_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mod && !expire_i) |=> !flag_q);

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata_i[B_IE]) |=> !irq_o);

endmodule

// File: rtl/pit16.sv
module pit16
    import pit_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0]  pre;
    logic              restart, start, stop, load, tick, expire, running;
    logic [DATA_W-1:0] start_val, reload_val, load_val, count;

    pit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (bus_addr),
        .wr_i         (bus_wr),
        .rd_i         (bus_rd),
        .wdata_i      (bus_wdata),
        .rdata_o      (bus_rdata),
        .expire_i     (expire),
        .count_i      (count),
        .pre_o        (pre),
        .restart_o    (restart),
        .start_o      (start),
        .stop_o       (stop),
        .start_val_o  (start_val),
        .reload_val_o (reload_val),
        .load_o       (load),
        .load_val_o   (load_val),
        .irq_o        (irq)
    );

    pit_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running && !restart),
        .clear_i (start),
        .pre_i   (pre),
        .tick_o  (tick)
    );

    pit_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .stop_i       (stop),
        .tick_i       (tick),
        .load_i       (load),
        .load_val_i   (load_val),
        .start_val_i  (start_val),
        .reload_val_i (reload_val),
        .count_o      (count),
        .expire_o     (expire),
        .running_o    (running)
    );

endmodule

// File: tb/test_pit16.sv
module test_pit16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Behavioural reference state
    logic [15:0] m_cfg = '0, m_mod = '0, m_cnt = '0;
    logic        m_flag = 1'b0;
    int          m_div = 0;

    always #2 clk = ~clk;

    pit16 i_pit16 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int divn();
        return 2 << m_cfg[11:8];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = '0; m_mod = '0; m_cnt = '0; m_flag = 1'b0; m_div = 0;
        end else begin
            logic [15:0] w, lim;
            bit wr0, wr2, rs, run, tk, ex;
            w   = bus_wdata;
            run = m_cfg[0];
            wr0 = bus_wr && bus_addr == 3'd0;
            wr2 = bus_wr && bus_addr == 3'd2;
            rs  = wr0 && (((m_cfg ^ w) & 16'h0F73) != 16'h0);
            tk  = run && !rs && (m_div == divn() - 1);
            ex  = tk && (m_cnt == 16'h0);
            lim = m_cfg[1] ? m_mod : 16'hFFFF;
            if (rs) begin
                if (w[0]) begin
                    m_cnt = w[1] ? m_mod : 16'hFFFF;
                    m_div = 0;
                end
            end else begin
                if (run) m_div = tk ? 0 : m_div + 1;
                if (wr2 && m_cfg[4]) m_cnt = w;
                else if (ex)         m_cnt = lim;
                else if (tk)         m_cnt = m_cnt - 16'h1;
            end
            if (ex) m_flag = 1'b1;
            else if ((wr0 && w[2]) || wr2) m_flag = 1'b0;
            if (wr0) m_cfg = w & 16'h0F7B;
            if (wr2) m_mod = w;
        end
    end

    function automatic logic [15:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cfg | {13'h0, m_flag, 2'b00};
            3'd2: return m_mod;
            3'd4: return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // R5: irq compared with the reference on every clock
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk("R5 irq level", {15'h0, irq}, {15'h0, m_flag & m_cfg[3]});
    end

    task automatic bus(input bit w, input bit r, input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        bus(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        bus(1'b0, 1'b1, a, 16'h0);
        @(negedge clk);
        chk(tag, bus_rdata, model_read(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) bus(1'b0, 1'b0, 3'd0, 16'h0);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_chk(3'd0, "R1 ctrl after reset");
        rd_chk(3'd2, "R1 modulus after reset");
        rd_chk(3'd4, "R1 count after reset");
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);

        // R6/R3 periodic reload, divide 2
        wr_reg(3'd2, 16'd5);
        wr_reg(3'd0, 16'h000B);
        idle(3);
        rd_chk(3'd4, "R3 count decrement");
        idle(20);
        rd_chk(3'd0, "R6 flag after expiry");
        rd_chk(3'd4, "R6 reload from modulus");

        // R4 write-one-to-clear, write zero keeps
        wr_reg(3'd0, 16'h000F);
        rd_chk(3'd0, "R4 flag cleared by one");
        idle(14);
        wr_reg(3'd0, 16'h000B);
        rd_chk(3'd0, "R4 flag kept by zero");

        // R7 enable-only change keeps counting
        wr_reg(3'd0, 16'h0003);
        rd_chk(3'd4, "R7 count undisturbed");
        idle(3);
        rd_chk(3'd4, "R7 count continues");

        // R7/R3 prescale change restarts, divide 16
        wr_reg(3'd0, 16'h0303);
        idle(10);
        rd_chk(3'd4, "R7 restart reload");
        idle(40);
        rd_chk(3'd4, "R3 prescaled rate");

        // R10/R9 modulus write without overwrite in reload mode
        wr_reg(3'd2, 16'd2);
        rd_chk(3'd4, "R10 count untouched");
        rd_chk(3'd0, "R9 flag cleared by modulus write");
        idle(100);
        rd_chk(3'd4, "R10 new modulus at reload");
        rd_chk(3'd0, "R6 flag set again");

        // R4 priority: clear on the expiry cycle
        wr_reg(3'd0, 16'h000B);
        idle(1);
        while (!(m_cfg[0] && m_cnt == 16'h0 && m_div == divn() - 1)) idle(1);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = 3'd0; bus_wdata = 16'h000F;
        rd_chk(3'd0, "R4 set beats clear");

        // R6/R10 free run with overwrite
        wr_reg(3'd0, 16'h0011);
        rd_chk(3'd4, "R6 free-run start at FFFF");
        wr_reg(3'd2, 16'd3);
        rd_chk(3'd4, "R10 overwrite load");
        idle(10);
        rd_chk(3'd4, "R6 free-run reload FFFF");
        rd_chk(3'd0, "R6 free-run flag");

        // R10 free run without overwrite
        wr_reg(3'd0, 16'h0001);
        wr_reg(3'd2, 16'd9);
        rd_chk(3'd4, "R10 free-run ignores modulus");

        // R8 disabled holds
        wr_reg(3'd0, 16'h0000);
        rd_chk(3'd4, "R8 count at stop");
        idle(10);
        rd_chk(3'd4, "R8 count held");

        // R11 / R2 decode
        wr_reg(3'd4, 16'h1234);
        rd_chk(3'd4, "R11 count write ignored");
        wr_reg(3'd6, 16'hBEEF);
        rd_chk(3'd0, "R11 bad offset ctrl unchanged");
        rd_chk(3'd2, "R11 bad offset modulus unchanged");
        rd_chk(3'd6, "R2 undefined offset reads zero");
        wr_reg(3'd0, 16'hFFFB);
        rd_chk(3'd0, "R2 control bit layout");
        wr_reg(3'd0, 16'h0000);
        rd_chk(3'd0, "R2 control cleared");
        idle(2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule